// File: doc/BRIEF.md
# Byte-Bus Command Sequencer

This block sits between an external microcontroller and a storage-class USB engine. The microcontroller talks to it over a byte-wide parallel bus with chip select, read and write strobes, and one address line. The address line tells a command byte from a data byte. The sequencer decodes each command opcode and gathers the argument bytes that the opcode expects. It places a single result byte in a one-shot response register for the host to read back.

It handles five housekeeping commands:
- A liveness probe that answers with the bitwise complement of its argument.
- A query for the highest logical unit, which needs a key byte before it answers.
- A unit selection that needs a key byte and then the new unit number.
- A sleep request that holds the core clock enable low.
- A full internal reset.

Events that finish asynchronously pull an active-low interrupt line low. These are an external engine event, completion of a wake-up, and a key-byte error. The line stays low until the host reads the status byte. The USB engine is stubbed by the `max_unit`, `evt_done` and `evt_code` inputs.

Top module: `mcu_cmd_ctrl`

## Requirements
- R1: Command 06h followed by one data byte x makes the next data read return ~x. The response is one-shot: a data read with nothing pending returns 00h.
- R2: Command 0Ah followed by data byte 38h makes the next data read return the value on `max_unit` sampled at that data write.
- R3: When the key byte of 0Ah or 0Bh is wrong, no response is produced, so a data read returns 00h. The status byte becomes E1h and `irq_n` goes low.
- R4: Command 0Bh followed by data 34h and then data n drives `unit_sel` to n. Bad key bytes leave `unit_sel` unchanged.
- R5: A command write with an opcode outside {03h, 05h, 06h, 0Ah, 0Bh} is ignored, and an argument still pending keeps being collected.
- R6: Command 03h raises `sleep_req`. Data writes leave it high. Any command write lowers it on the next clock.
- R7: After the waking command write, `irq_n` falls exactly WAKE_CYC clocks later and the status byte reads A5h.
- R8: Command 05h holds `reset_req` high for RST_CYC clocks. It then clears `unit_sel` to 0, releases `irq_n` and drops any pending response.
- R9: Outside sleep, wake and reset, an `evt_done` pulse pulls `irq_n` low and loads `evt_code` as the status byte. `irq_n` stays low until a status read and goes high on the clock after it.
- R10: An event that coincides with a status read wins: the read returns the old status, and `irq_n` stays low with the new code. A key-byte error beats a coinciding event.
- R11: After reset, `irq_n`, `sleep_req` and `reset_req` are inactive, `unit_sel` is 0 and a data read returns 00h.
- R12: The bus is decoded only while `cs_n` is low. With `a0` high, a write is a command and a read returns the status. With `a0` low, both are data. A write with `cs_n` high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | High: command/status, low: data |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| irq_n | output | 1 | Interrupt, active low |
| sleep_req | output | 1 | Core clock stop request |
| reset_req | output | 1 | Internal reset in progress |
| max_unit | input | 8 | Highest unit number from storage stub |
| evt_done | input | 1 | Asynchronous event completion pulse |
| evt_code | input | 8 | Status code of that event |
| unit_sel | output | 8 | Currently selected unit |

## Verification
An engine event can arrive in the same cycle as the host status read that clears the interrupt. A key-byte error can also coincide with an event. The bench drives `evt_done` during the status-read strobe. It expects the read to return the earlier code, and it expects `irq_n` to still be low on the next clock with the new code waiting. It then writes a bad key byte in the cycle of another event and expects the error code to be the one latched.

// File: rtl/mcu_cmd_pkg.sv
package mcu_cmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARG1, S_ARG2, S_SLEEP, S_WAKE, S_RST
  } seq_state_e;

  localparam logic [7:0] OP_PING    = 8'h06;
  localparam logic [7:0] OP_UNITQ   = 8'h0A;
  localparam logic [7:0] OP_UNITSET = 8'h0B;
  localparam logic [7:0] OP_SLEEP   = 8'h03;
  localparam logic [7:0] OP_RESET   = 8'h05;

  localparam logic [7:0] KEY_QUERY  = 8'h38;
  localparam logic [7:0] KEY_SET    = 8'h34;

  localparam logic [7:0] ST_ERR     = 8'hE1;
  localparam logic [7:0] ST_WAKE    = 8'hA5;
endpackage

// File: rtl/bus_decode.sv
module bus_decode (
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic a0,
  output logic cmd_wr,
  output logic dat_wr,
  output logic stat_rd,
  output logic dat_rd
);
  logic sel_wr, sel_rd;

  assign sel_wr  = !cs_n && !wr_n;
  assign sel_rd  = !cs_n && !rd_n && wr_n;
  assign cmd_wr  = sel_wr &&  a0;
  assign dat_wr  = sel_wr && !a0;
  assign stat_rd = sel_rd &&  a0;
  assign dat_rd  = sel_rd && !a0;
endmodule

// File: rtl/delay_timer.sv
module delay_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/status_irq.sv
module status_irq
  import mcu_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       set_err,
  input  logic       set_wake,
  input  logic       set_evt,
  input  logic [7:0] evt_code,
  input  logic       clr_rd,
  output logic [7:0] stat,
  output logic       irq_n
);
  logic [7:0] stat_q, stat_d;
  logic       irq_q, irq_d;

  always_comb begin
    stat_d = stat_q;
    irq_d  = irq_q;
    if (flush) begin
      stat_d = '0;
      irq_d  = 1'b0;
    end else if (set_err) begin
      stat_d = ST_ERR;
      irq_d  = 1'b1;
    end else if (set_wake) begin
      stat_d = ST_WAKE;
      irq_d  = 1'b1;
    end else if (set_evt) begin
      stat_d = evt_code;
      irq_d  = 1'b1;
    end else if (clr_rd) begin
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat  = stat_q;
  assign irq_n = ~irq_q;
endmodule

// File: rtl/mcu_cmd_ctrl.sv
module mcu_cmd_ctrl
  import mcu_cmd_pkg::*;
#(
  parameter int WAKE_CYC = 2000,
  parameter int RST_CYC  = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       a0,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       irq_n,
  output logic       sleep_req,
  output logic       reset_req,
  input  logic [7:0] max_unit,
  input  logic       evt_done,
  input  logic [7:0] evt_code,
  output logic [7:0] unit_sel
);
  logic       cmd_wr, dat_wr, stat_rd, dat_rd;
  logic       wake_done, rst_done, err_p, core_en, evt_ok;
  logic [7:0] stat;

  seq_state_e state_q, state_d;
  logic [7:0] op_q, op_d;
  logic [7:0] rsp_q, rsp_d;
  logic       vld_q, vld_d;
  logic [7:0] unit_q, unit_d;

  bus_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .cmd_wr(cmd_wr), .dat_wr(dat_wr), .stat_rd(stat_rd), .dat_rd(dat_rd)
  );

  delay_timer #(.LIMIT(WAKE_CYC)) u_wake_tmr (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_WAKE), .done(wake_done)
  );

  delay_timer #(.LIMIT(RST_CYC)) u_rst_tmr (
    .clk(clk), .rst_n(rst_n), .run(state_q == S_RST), .done(rst_done)
  );

  assign evt_ok = evt_done &&
                  (state_q == S_IDLE || state_q == S_ARG1 || state_q == S_ARG2);

  status_irq u_stat (
    .clk(clk), .rst_n(rst_n), .flush(rst_done), .set_err(err_p),
    .set_wake(wake_done), .set_evt(evt_ok), .evt_code(evt_code),
    .clr_rd(stat_rd), .stat(stat), .irq_n(irq_n)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    rsp_d   = rsp_q;
    vld_d   = vld_q;
    unit_d  = unit_q;
    err_p   = 1'b0;
    if (dat_rd) vld_d = 1'b0;
    case (state_q)
      S_IDLE, S_ARG1, S_ARG2: begin
        if (cmd_wr) begin
          case (din)
            OP_PING, OP_UNITQ, OP_UNITSET: begin
              state_d = S_ARG1;
              op_d    = din;
              vld_d   = 1'b0;
            end
            OP_SLEEP: begin
              state_d = S_SLEEP;
              vld_d   = 1'b0;
            end
            OP_RESET: begin
              state_d = S_RST;
              vld_d   = 1'b0;
            end
            default: ;
          endcase
        end else if (dat_wr && state_q == S_ARG1) begin
          state_d = S_IDLE;
          case (op_q)
            OP_PING: begin
              rsp_d = ~din;
              vld_d = 1'b1;
            end
            OP_UNITQ: begin
              if (din == KEY_QUERY) begin
                rsp_d = max_unit;
                vld_d = 1'b1;
              end else begin
                err_p = 1'b1;
              end
            end
            default: begin
              if (din == KEY_SET) state_d = S_ARG2;
              else                err_p   = 1'b1;
            end
          endcase
        end else if (dat_wr && state_q == S_ARG2) begin
          unit_d  = din;
          state_d = S_IDLE;
        end
      end
      S_SLEEP: if (cmd_wr)    state_d = S_WAKE;
      S_WAKE:  if (wake_done) state_d = S_IDLE;
      default: begin
        if (rst_done) begin
          state_d = S_IDLE;
          unit_d  = '0;
          vld_d   = 1'b0;
        end
      end
    endcase
  end

  // clock enable: frozen while asleep, woken by a command write
  assign core_en = (state_q != S_SLEEP) || cmd_wr;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      rsp_q   <= '0;
      vld_q   <= 1'b0;
      unit_q  <= '0;
    end else if (core_en) begin
      state_q <= state_d;
      op_q    <= op_d;
      rsp_q   <= rsp_d;
      vld_q   <= vld_d;
      unit_q  <= unit_d;
    end
  end

  assign dout      = dat_rd ? (vld_q ? rsp_q : 8'h00) : (stat_rd ? stat : 8'h00);
  assign sleep_req = (state_q == S_SLEEP);
  assign reset_req = (state_q == S_RST);
  assign unit_sel  = unit_q;
endmodule

// File: rtl/mcu_cmd_chk.sv
module mcu_cmd_chk
  import mcu_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       a0,
  input logic [7:0] din,
  input logic       evt_done,
  input logic       irq_n,
  input logic       sleep_req,
  input logic       reset_req,
  input logic [7:0] unit_sel,
  input logic       err_p,
  input logic       wake_done
);
  // R6 R8
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_req && reset_req));

  // R6
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> $past(!cs_n && !wr_n && a0 && din == OP_SLEEP));

  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && wr_n && a0 && !evt_done && !err_p && !wake_done) |=> irq_n);

  // R4
  unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unit_sel) |-> ($past(!cs_n && !wr_n && !a0) || $past(reset_req)));
endmodule

bind mcu_cmd_ctrl mcu_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
  .din(din), .evt_done(evt_done), .irq_n(irq_n), .sleep_req(sleep_req),
  .reset_req(reset_req), .unit_sel(unit_sel), .err_p(err_p),
  .wake_done(wake_done)
);

// File: tb/test_mcu_cmd_ctrl.sv
module test_mcu_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE_T = 40;
  localparam int RST_T  = 30;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, rd_n, wr_n, a0, evt_done;
  logic [7:0] din, max_unit, evt_code, dout, unit_sel;
  logic       irq_n, sleep_req, reset_req;
  logic [7:0] v;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         over = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcu_cmd_ctrl #(.WAKE_CYC(WAKE_T), .RST_CYC(RST_T)) i_mcu_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
    .din(din), .dout(dout), .irq_n(irq_n), .sleep_req(sleep_req),
    .reset_req(reset_req), .max_unit(max_unit), .evt_done(evt_done),
    .evt_code(evt_code), .unit_sel(unit_sel)
  );

  function automatic logic [7:0] ping_exp(input logic [7:0] x);
    return ~x;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic is_cmd, input logic [7:0] val);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; a0 = is_cmd; din = val;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1; a0 = 1'b0; din = 8'h00;
  endtask

  task automatic bus_rd(input logic is_stat, output logic [7:0] val);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; a0 = is_stat;
    #1 val = dout;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; a0 = 1'b0;
  endtask

  task automatic fire_evt(input logic [7:0] code);
    @(negedge clk); evt_done = 1'b1; evt_code = code;
    @(negedge clk); evt_done = 1'b0;
  endtask

  task automatic finish_up();
    if (!over) begin
      over = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; a0 = 1'b0;
    din = 8'h00; evt_done = 1'b0; evt_code = 8'h00; max_unit = 8'h07;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 irq_n", {7'd0, irq_n}, 8'h01);
    check("R11 sleep_req", {7'd0, sleep_req}, 8'h00);
    check("R11 reset_req", {7'd0, reset_req}, 8'h00);
    check("R11 unit_sel", unit_sel, 8'h00);
    bus_rd(1'b0, v); check("R11 data read", v, 8'h00);

    // R1 directed and one-shot
    bus_wr(1'b1, 8'h06); bus_wr(1'b0, 8'h57);
    bus_rd(1'b0, v); check("R1 ping 57", v, 8'hA8);
    bus_rd(1'b0, v); check("R1 one-shot", v, 8'h00);

    // R1 random
    for (int i = 0; i < 16; i++) begin
      logic [7:0] x;
      x = 8'($urandom);
      bus_wr(1'b1, 8'h06); bus_wr(1'b0, x);
      bus_rd(1'b0, v); check("R1 ping random", v, ping_exp(x));
    end

    // R12 deselected write is ignored
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; a0 = 1'b1; din = 8'h06;
    @(negedge clk); wr_n = 1'b1; a0 = 1'b0; din = 8'h00;
    bus_wr(1'b0, 8'h11);
    bus_rd(1'b0, v); check("R12 cs_n gating", v, 8'h00);

    // R2 query
    max_unit = 8'($urandom_range(1, 15));
    bus_wr(1'b1, 8'h0A); bus_wr(1'b0, 8'h38);
    bus_rd(1'b0, v); check("R2 unit query", v, max_unit);

    // R3 bad key on query
    bus_wr(1'b1, 8'h0A); bus_wr(1'b0, 8'h39);
    bus_rd(1'b0, v); check("R3 no data", v, 8'h00);
    check("R3 irq low", {7'd0, irq_n}, 8'h00);
    bus_rd(1'b1, v); check("R3 status", v, 8'hE1);
    check("R9 irq released", {7'd0, irq_n}, 8'h01);

    // R4 unit select, then bad key
    bus_wr(1'b1, 8'h0B); bus_wr(1'b0, 8'h34); bus_wr(1'b0, 8'h02);
    check("R4 unit set", unit_sel, 8'h02);
    bus_wr(1'b1, 8'h0B); bus_wr(1'b0, 8'h35); bus_wr(1'b0, 8'h09);
    check("R4 bad key keeps unit", unit_sel, 8'h02);
    bus_rd(1'b1, v); check("R3 set-key status", v, 8'hE1);

    // R5 unknown opcode while argument pending
    bus_wr(1'b1, 8'h06); bus_wr(1'b1, 8'h7E); bus_wr(1'b0, 8'h0F);
    bus_rd(1'b0, v); check("R5 unknown ignored", v, 8'hF0);

    // R9 random events
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c;
      c = 8'($urandom);
      fire_evt(c);
      check("R9 irq on event", {7'd0, irq_n}, 8'h00);
      bus_rd(1'b1, v); check("R9 event code", v, c);
      check("R9 irq cleared", {7'd0, irq_n}, 8'h01);
    end

    // R10 event during status read
    fire_evt(8'h21);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; a0 = 1'b1; evt_done = 1'b1; evt_code = 8'h33;
    #1 v = dout;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; a0 = 1'b0; evt_done = 1'b0;
    check("R10 read returns old", v, 8'h21);
    check("R10 irq held", {7'd0, irq_n}, 8'h00);
    bus_rd(1'b1, v); check("R10 new code kept", v, 8'h33);

    // R10 error beats event
    bus_wr(1'b1, 8'h0A);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; a0 = 1'b0; din = 8'h00;
    evt_done = 1'b1; evt_code = 8'h44;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1; evt_done = 1'b0;
    bus_rd(1'b1, v); check("R10 error priority", v, 8'hE1);

    // R6 sleep
    bus_wr(1'b1, 8'h03);
    check("R6 sleep entry", {7'd0, sleep_req}, 8'h01);
    bus_wr(1'b0, 8'h55);
    check("R6 data keeps sleep", {7'd0, sleep_req}, 8'h01);
    bus_wr(1'b1, 8'h00);
    check("R6 command wakes", {7'd0, sleep_req}, 8'h00);

    // R7 wake interrupt timing
    repeat (WAKE_T - 1) @(negedge clk);
    check("R7 not yet", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    check("R7 wake irq", {7'd0, irq_n}, 8'h00);
    bus_rd(1'b1, v); check("R7 wake status", v, 8'hA5);

    // R8 full reset
    bus_wr(1'b1, 8'h0B); bus_wr(1'b0, 8'h34); bus_wr(1'b0, 8'h05);
    fire_evt(8'h66);
    bus_wr(1'b1, 8'h05);
    check("R8 reset_req high", {7'd0, reset_req}, 8'h01);
    repeat (RST_T - 1) @(negedge clk);
    check("R8 still resetting", {7'd0, reset_req}, 8'h01);
    @(negedge clk);
    check("R8 reset_req low", {7'd0, reset_req}, 8'h00);
    check("R8 unit cleared", unit_sel, 8'h00);
    check("R8 irq released", {7'd0, irq_n}, 8'h01);
    bus_rd(1'b0, v); check("R8 no pending data", v, 8'h00);

    finish_up();
  end
endmodule